// File: doc/BRIEF.md
# Dual-Panel Pixel Stream Formatter

This block sits between two pixel FIFOs and the display data pins. One FIFO carries encoded pixel groups for the upper half of the screen and the other carries groups for the lower half. On every pixel-clock enable the formatter takes one group from each FIFO it needs and places the groups on a registered 16-bit pin bus. The pin layout depends on the panel configuration.

Three layouts are supported. In the passive single-panel layout, one line is presented at a time from the upper source. In the passive dual-panel layout, two lines are presented at once, one per half, on separate pin groups. This doubles the pin width. In the active layout, the full bus comes from the upper source and the dual select is forced off.

The block also issues refill requests to the two FIFO sources, alternating between them when both ask. It keeps a per-half pixel position that wraps at the configured line length.

Top module: `dpanel_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pins`, `underrun`, `fetch_req`, `upper_pos` and `lower_pos` become 0.
- R2: Passive single-panel monochrome with `cfg_wide_mono`=0 (`cfg_active`=0, `cfg_dual`=0, `cfg_colour`=0): after a beat, `pins[3:0]` holds `up_data[3:0]` and `pins[15:4]` is 0.
- R3: Passive single-panel with `cfg_colour`=1 or `cfg_wide_mono`=1: after a beat, `pins[7:0]` holds `up_data[7:0]` and `pins[15:8]` is 0.
- R4: Passive dual-panel (`cfg_dual`=1, `cfg_active`=0), where `cfg_wide_mono` has no effect. For monochrome, a beat places upper `[3:0]` on `pins[3:0]` and lower `[3:0]` on `pins[7:4]`, and `pins[15:8]` is 0. For colour, a beat places upper `[7:0]` on `pins[7:0]` and lower `[7:0]` on `pins[15:8]`.
- R5: With `cfg_active`=1, a beat places `up_data[15:0]` on `pins`. `cfg_dual` is treated as 0: `lo_ready` stays 0, `lower_pos` holds, and no fetch for source 1 is issued.
- R6: A beat occurs in a cycle with `pix_en`=1 and `up_valid`=1, and also `lo_valid`=1 when dual is in effect. In that cycle `up_ready` is 1, and `lo_ready` is 1 only if dual is in effect. In any other cycle both readies are 0.
- R7: A cycle with `pix_en`=1 but missing data sets `underrun` to 1 for the next cycle. In that case `pins` and both positions hold their values.
- R8: Each beat advances `upper_pos`, wrapping to 0 after `cfg_line_len`-1. `lower_pos` advances with it on dual beats only and otherwise holds.
- R9: `fetch_req`/`fetch_src` are registered one cycle after `up_want`/`lo_want`. Source 1 is eligible only in dual mode. When both sources are eligible, the source not granted last is chosen; a lone eligible source is chosen directly. The first contention after reset goes to source 0.
- R10: While `pix_en` is 0, no data is consumed and `underrun` stays 0, whatever the FIFO valids are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active | input | 1 | 1 selects the active layout |
| cfg_dual | input | 1 | 1 selects dual-panel (passive only) |
| cfg_colour | input | 1 | 1 selects colour lane width |
| cfg_wide_mono | input | 1 | 1 selects 8-pin single-panel monochrome |
| cfg_line_len | input | 12 | Pixel groups per line |
| pix_en | input | 1 | Pixel-clock enable |
| up_data | input | 16 | Upper-half pixel group |
| up_valid | input | 1 | Upper FIFO has data |
| up_ready | output | 1 | Upper group consumed this cycle |
| lo_data | input | 8 | Lower-half pixel group |
| lo_valid | input | 1 | Lower FIFO has data |
| lo_ready | output | 1 | Lower group consumed this cycle |
| up_want | input | 1 | Upper FIFO asks for refill |
| lo_want | input | 1 | Lower FIFO asks for refill |
| fetch_req | output | 1 | Refill request issued |
| fetch_src | output | 1 | Source of the request (0 upper, 1 lower) |
| pins | output | 16 | Display data pins |
| underrun | output | 1 | Previous pixel enable found data missing |
| upper_pos | output | 12 | Upper-half pixel position |
| lower_pos | output | 12 | Lower-half pixel position |

## Verification
In dual mode, a pixel enable can arrive when the upper FIFO has data but the lower one does not. The same cycle can also carry contending refill requests from both sources. The bench provokes this by randomising the two valids, the two wants and the enable independently. A cycle-level reference model then judges that no upper group is consumed, `underrun` rises, the pins and positions hold, and the refill grant still alternates. Mode switches between phases also check that `lower_pos` holds outside dual operation and that the wrap happens at a short line length.

// File: rtl/fmt_pkg.sv
// Package: shared layout encoding for the pixel stream formatter.
// Assumes: nothing beyond IEEE 1800-2017.
package fmt_pkg;
    // Pin layout selected after the active/dual priority is resolved.
    typedef enum logic [1:0] {
        LAY_SINGLE = 2'd0,
        LAY_DUAL   = 2'd1,
        LAY_ACTIVE = 2'd2
    } layout_e;
endpackage

// File: rtl/fmt_mode_dec.sv
// Module: fmt_mode_dec
// Resolves the raw configuration bits into an effective layout and lane width.
// The active layout overrides the dual select. In dual layout the 8-pin
// monochrome option is ignored, so only colour picks the wide lane.
// Assumes: configuration is quasi-static relative to the pixel stream.
module fmt_mode_dec
    import fmt_pkg::*;
(
    input  logic    cfg_active,
    input  logic    cfg_dual,
    input  logic    cfg_colour,
    input  logic    cfg_wide_mono,
    output layout_e layout,
    output logic    lane_wide,
    output logic    dual_eff
);
    // Layout priority: active first, then dual, else single.
    always_comb begin
        if (cfg_active) begin
            layout    = LAY_ACTIVE;
            lane_wide = 1'b1;
        end else if (cfg_dual) begin
            layout    = LAY_DUAL;
            lane_wide = cfg_colour;
        end else begin
            layout    = LAY_SINGLE;
            lane_wide = cfg_colour | cfg_wide_mono;
        end
    end

    // Dual operation is in effect only in the passive dual layout.
    assign dual_eff = (layout == LAY_DUAL);
endmodule

// File: rtl/fmt_pin_mux.sv
// Module: fmt_pin_mux
// Places upper and lower pixel groups on the pin bus for the current layout.
// Pins not used by the layout are driven to 0.
// Assumes: OUT_W >= 2*COL_W and COL_W >= MONO_W; LO_W == COL_W.
module fmt_pin_mux
    import fmt_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter int COL_W  = 8,
    parameter int MONO_W = 4
) (
    input  layout_e          layout,
    input  logic             lane_wide,
    input  logic [OUT_W-1:0] up_data,
    input  logic [COL_W-1:0] lo_data,
    output logic [OUT_W-1:0] pins_nxt
);
    localparam int LANE_N = 2;

    logic [OUT_W-1:0] lane_mask;
    logic [OUT_W-1:0] dual_word;
    logic [COL_W-1:0] up_lane;
    logic [COL_W-1:0] lo_lane;
    logic [COL_W-1:0] lane_src [LANE_N];

    // Truncate each source to the active lane width.
    always_comb begin
        if (lane_wide) begin
            up_lane = up_data[COL_W-1:0];
            lo_lane = lo_data;
        end else begin
            up_lane = {{(COL_W-MONO_W){1'b0}}, up_data[MONO_W-1:0]};
            lo_lane = {{(COL_W-MONO_W){1'b0}}, lo_data[MONO_W-1:0]};
        end
    end

    assign lane_src[0] = up_lane;
    assign lane_src[1] = lo_lane;

    // Build the dual word: lane k starts at k times the lane width.
    always_comb begin
        dual_word = '0;
        for (int k = 0; k < LANE_N; k++) begin
            if (lane_wide) begin
                dual_word[k*COL_W +: COL_W] = lane_src[k];
            end else begin
                dual_word[k*MONO_W +: MONO_W] = lane_src[k][MONO_W-1:0];
            end
        end
    end

    // Single-layout mask covers one lane of the selected width.
    always_comb begin
        lane_mask = '0;
        lane_mask[MONO_W-1:0] = '1;
        if (lane_wide) begin
            lane_mask[COL_W-1:0] = '1;
        end
    end

    // Final layout selection.
    always_comb begin
        unique case (layout)
            LAY_ACTIVE: pins_nxt = up_data;
            LAY_DUAL:   pins_nxt = dual_word;
            default:    pins_nxt = up_data & lane_mask;
        endcase
    end
endmodule

// File: rtl/fmt_line_ctr.sv
// Module: fmt_line_ctr
// Pixel position within a line for one screen half; wraps at line length.
// Assumes: line_len >= 1 while advancing.
module fmt_line_ctr #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [POS_W-1:0] line_len,
    output logic [POS_W-1:0] pos
);
    logic last_px;

    assign last_px = (pos == line_len - POS_W'(1));

    // Advance on a beat, returning to 0 after the last pixel of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (adv) begin
            pos <= last_px ? '0 : pos + POS_W'(1);
        end
    end
endmodule

// File: rtl/fmt_fetch_arb.sv
// Module: fmt_fetch_arb
// Issues refill requests to the two FIFO sources and alternates between them
// when both ask. Source 1 is eligible only when dual operation is in effect.
// Assumes: a request is taken by the fetch engine in the cycle it is shown.
module fmt_fetch_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_eff,
    input  logic up_want,
    input  logic lo_want,
    output logic fetch_req,
    output logic fetch_src
);
    logic elig_up;
    logic elig_lo;
    logic pick;
    logic last_src;

    assign elig_up = up_want;
    assign elig_lo = lo_want & dual_eff;

    // Choose the opposite of the last grant under contention.
    always_comb begin
        if (elig_up && elig_lo) begin
            pick = ~last_src;
        end else begin
            pick = elig_lo;
        end
    end

    // Register the request and remember the winner for alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req <= 1'b0;
            fetch_src <= 1'b0;
            last_src  <= 1'b1;
        end else begin
            fetch_req <= elig_up | elig_lo;
            if (elig_up | elig_lo) begin
                fetch_src <= pick;
                last_src  <= pick;
            end
        end
    end
endmodule

// File: rtl/dpanel_fmt.sv
// Module: dpanel_fmt (top)
// Pixel stream formatter: pairs upper/lower FIFO groups onto a registered pin
// bus per pixel enable. It flags underruns, tracks per-half line position and
// issues alternating refill requests.
// Assumes: FIFO data is valid when its valid is high; ready is combinational
// from valid and pix_en; configuration changes only between frames.
module dpanel_fmt
    import fmt_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter int COL_W  = 8,
    parameter int MONO_W = 4,
    parameter int POS_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_active,
    input  logic             cfg_dual,
    input  logic             cfg_colour,
    input  logic             cfg_wide_mono,
    input  logic [POS_W-1:0] cfg_line_len,
    input  logic             pix_en,
    input  logic [OUT_W-1:0] up_data,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [COL_W-1:0] lo_data,
    input  logic             lo_valid,
    output logic             lo_ready,
    input  logic             up_want,
    input  logic             lo_want,
    output logic             fetch_req,
    output logic             fetch_src,
    output logic [OUT_W-1:0] pins,
    output logic             underrun,
    output logic [POS_W-1:0] upper_pos,
    output logic [POS_W-1:0] lower_pos
);
    localparam int HALVES = 2;

    layout_e          layout;
    logic             lane_wide;
    logic             dual_eff;
    logic             have_all;
    logic             beat;
    logic [OUT_W-1:0] pins_nxt;
    logic             half_adv [HALVES];
    logic [POS_W-1:0] half_pos [HALVES];

    fmt_mode_dec u_dec (
        .cfg_active   (cfg_active),
        .cfg_dual     (cfg_dual),
        .cfg_colour   (cfg_colour),
        .cfg_wide_mono(cfg_wide_mono),
        .layout       (layout),
        .lane_wide    (lane_wide),
        .dual_eff     (dual_eff)
    );

    // A beat needs the upper group, plus the lower group in dual operation.
    assign have_all = up_valid & (lo_valid | ~dual_eff);
    assign beat     = pix_en & have_all;
    assign up_ready = beat;
    assign lo_ready = beat & dual_eff;

    fmt_pin_mux #(
        .OUT_W (OUT_W),
        .COL_W (COL_W),
        .MONO_W(MONO_W)
    ) u_mux (
        .layout   (layout),
        .lane_wide(lane_wide),
        .up_data  (up_data),
        .lo_data  (lo_data),
        .pins_nxt (pins_nxt)
    );

    // Pin register: load on a beat, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= '0;
        end else if (beat) begin
            pins <= pins_nxt;
        end
    end

    // Underrun flag: one cycle after an enable that found data missing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else begin
            underrun <= pix_en & ~have_all;
        end
    end

    assign half_adv[0] = beat;
    assign half_adv[1] = beat & dual_eff;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        fmt_line_ctr #(
            .POS_W(POS_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (half_adv[h]),
            .line_len(cfg_line_len),
            .pos     (half_pos[h])
        );
    end

    assign upper_pos = half_pos[0];
    assign lower_pos = half_pos[1];

    fmt_fetch_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual_eff (dual_eff),
        .up_want  (up_want),
        .lo_want  (lo_want),
        .fetch_req(fetch_req),
        .fetch_src(fetch_src)
    );
endmodule

// File: rtl/dpanel_fmt_chk.sv
// Module: dpanel_fmt_chk
// Temporal checks on the formatter ports, bound into every dpanel_fmt.
// Assumes: reset is held for at least one clock edge at start.
module dpanel_fmt_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_active,
    input logic             cfg_dual,
    input logic             pix_en,
    input logic             up_valid,
    input logic             up_ready,
    input logic             lo_ready,
    input logic [OUT_W-1:0] pins,
    input logic             underrun,
    input logic             fetch_req,
    input logic             fetch_src
);
    // R6: lower group is consumed only in passive dual operation.
    p_lo_only_dual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ready |-> (cfg_dual && !cfg_active));

    // R6: upper group is consumed only with valid data under a pixel enable.
    p_up_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (up_valid && pix_en));

    // R7: an underrun leaves the pins untouched.
    p_hold_on_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $stable(pins));

    // R10: no enable means no underrun next cycle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !underrun);

    // R5 / R9: source 1 is requested only while passive dual was selected.
    p_lo_fetch_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_src) |-> $past(cfg_dual && !cfg_active));

    // R6: a beat never consumes the lower group without the upper one.
    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ready |-> up_ready);
endmodule

bind dpanel_fmt dpanel_fmt_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_active(cfg_active),
    .cfg_dual  (cfg_dual),
    .pix_en    (pix_en),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .lo_ready  (lo_ready),
    .pins      (pins),
    .underrun  (underrun),
    .fetch_req (fetch_req),
    .fetch_src (fetch_src)
);

// File: tb/sim_dpanel_fmt.sv
// Bench: behavioural cycle model of the formatter, compared every clock.
module sim_dpanel_fmt;
    localparam int POS_W = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_active, cfg_dual, cfg_colour, cfg_wide_mono;
    logic [11:0] cfg_line_len;
    logic        pix_en;
    logic [15:0] up_data;
    logic        up_valid, up_ready;
    logic [7:0]  lo_data;
    logic        lo_valid, lo_ready;
    logic        up_want, lo_want;
    logic        fetch_req, fetch_src;
    logic [15:0] pins;
    logic        underrun;
    logic [11:0] upper_pos, lower_pos;

    always #10 clk = ~clk;

    dpanel_fmt u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [15:0] m_pins;
    int          m_up, m_lo;
    bit          m_und, m_freq, m_fsrc, m_last;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // expected pin word for the current configuration
    function automatic logic [15:0] layout_word(input logic [15:0] u, input logic [7:0] l);
        logic [15:0] w = 16'h0;
        if (cfg_active) w = u;
        else if (cfg_dual) begin
            if (cfg_colour) w = {l, u[7:0]};
            else w = {8'h00, l[3:0], u[3:0]};
        end else if (cfg_colour || cfg_wide_mono) w = {8'h00, u[7:0]};
        else w = {12'h000, u[3:0]};
        return w;
    endfunction

    function automatic string pin_tag();
        if (cfg_active) return "R5 pins";
        if (cfg_dual) return "R4 pins";
        if (cfg_colour || cfg_wide_mono) return "R3 pins";
        return "R2 pins";
    endfunction

    task automatic cyc(input bit pe, input bit uv, input bit lv, input bit uw, input bit lw);
        bit dual, have, beat, eu, el, pick;
        pix_en = pe; up_valid = uv; lo_valid = lv; up_want = uw; lo_want = lw;
        up_data = 16'($urandom); lo_data = 8'($urandom);
        #1;
        dual = cfg_dual && !cfg_active;
        have = uv && (lv || !dual);
        beat = pe && have;
        chk("R6 up_ready", up_ready, beat);
        chk("R6 lo_ready", lo_ready, beat && dual);
        if (!pe) chk("R10 no consume", up_ready | lo_ready, 0);
        if (beat) begin
            m_pins = layout_word(up_data, lo_data);
            m_up = (m_up == int'(cfg_line_len) - 1) ? 0 : m_up + 1;
            if (dual) m_lo = (m_lo == int'(cfg_line_len) - 1) ? 0 : m_lo + 1;
        end
        m_und = pe && !have;
        eu = uw; el = lw && dual;
        m_freq = eu || el;
        pick = (eu && el) ? !m_last : el;
        if (m_freq) begin m_fsrc = pick; m_last = pick; end
        @(posedge clk); #1;
        chk(pin_tag(), pins, m_pins);
        chk("R7 underrun", underrun, m_und);
        if (!pe) chk("R10 underrun", underrun, 0);
        chk("R9 fetch_req", fetch_req, m_freq);
        chk("R9 fetch_src", fetch_src, m_fsrc);
        chk("R8 upper_pos", upper_pos, m_up);
        chk(cfg_active ? "R5 lower_pos" : "R8 lower_pos", lower_pos, m_lo);
    endtask

    task automatic set_cfg(input bit a, input bit d, input bit c, input bit w, input int len);
        cfg_active = a; cfg_dual = d; cfg_colour = c; cfg_wide_mono = w;
        cfg_line_len = 12'(len);
    endtask

    task automatic run_rand(input int n);
        for (int i = 0; i < n; i++) begin
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
                $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1);
        end
    endtask

    initial begin
        rst_n = 1'b0; pix_en = 0; up_valid = 0; lo_valid = 0; up_want = 0; lo_want = 0;
        up_data = 16'hFFFF; lo_data = 8'hFF;
        set_cfg(0, 1, 1, 0, 7);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pins", pins, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 fetch_req", fetch_req, 0);
        chk("R1 upper_pos", upper_pos, 0);
        chk("R1 lower_pos", lower_pos, 0);
        m_pins = 0; m_up = 0; m_lo = 0; m_und = 0; m_freq = 0; m_fsrc = 0; m_last = 1;
        rst_n = 1'b1;
        // first contention goes to source 0 (R9)
        cyc(0, 0, 0, 1, 1);
        chk("R9 first grant", fetch_src, 0);
        cyc(0, 0, 0, 1, 1);
        chk("R9 alternate", fetch_src, 1);
        // dual colour, lower missing while upper present (R7)
        cyc(1, 1, 0, 1, 1);
        cyc(1, 1, 1, 1, 1);
        run_rand(300);
        set_cfg(0, 1, 0, 1, 7);  run_rand(300);   // dual mono, wide ignored
        set_cfg(0, 0, 0, 0, 7);  run_rand(300);   // single mono narrow
        set_cfg(0, 0, 0, 1, 7);  run_rand(200);   // single mono wide
        set_cfg(0, 0, 1, 0, 5);  run_rand(200);   // single colour, short line
        set_cfg(1, 1, 1, 0, 9);  run_rand(300);   // active, dual forced off
        set_cfg(0, 1, 1, 0, 5);                   // back to dual, short line wrap
        for (int i = 0; i < 12; i++) cyc(1, 1, 1, 0, 1);
        for (int i = 0; i < 20; i++) cyc(0, 1, 1, 0, 0); // idle enable (R10)
        run_rand(300);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule